// File: doc/BRIEF.md
# Q31 Saturating Add Execution Unit

This unit executes one fractional add instruction. Each cycle it may receive a 32-bit instruction word, together with a mode input that says which of two encodings the word uses: a full-width layout or a compact layout. The compact layout places the two source register fields in the opposite order. The unit decodes the word and drives the two source register indices to an external register file. It takes the two 64-bit operands that come back in the same cycle. Only the low 32 bits of each operand are used, and they are treated as signed Q31 fractions.

The two fractions are added with signed saturation. The 32-bit result is sign-extended to 64 bits and presented one cycle later with a write strobe and the destination index. When the sum had to be clamped, a sticky flag at bit 20 of a 32-bit control register is set. A separate write port loads that register, and such a write wins over a flag set in the same cycle. A word that fits neither layout produces a reserved-instruction pulse. A valid word issued while the enable input is low produces a disabled pulse. In both of those cases no register write takes place and the flag is left alone.

Top module: `q31_sat_add_unit`

## Requirements
- R1: With `compact_i`=0, a word matches when bits 31:26 = 6'b011111, bits 10:6 = 5'b10110 and bits 5:0 = 6'b010000. Source A (rs) index is bits 25:21, source B (rt) index is bits 20:16 and the destination index is bits 15:11. The source indices appear on `src_a_idx_o`/`src_b_idx_o` in the same cycle.
- R2: With `compact_i`=1, a word matches when bits 31:26 = 6'b000000, bit 10 = 0 and bits 9:0 = 10'b1100000101. Source B (rt) index is bits 25:21, source A (rs) index is bits 20:16 and the destination index is bits 15:11.
- R3: When the signed sum of the low 32 bits of the two operands lies within [-2^31, 2^31-1], the low 32 bits of the result equal that sum. Operand bits 63:32 have no effect.
- R4: A sum above 2^31-1 gives 32'h7FFFFFFF.
- R5: A sum below -2^31 gives 32'h80000000.
- R6: Result bits 63:32 are copies of result bit 31.
- R7: A saturating add sets bit 20 of `ctrl_o` and leaves every other control bit unchanged. An add that does not saturate never clears bit 20.
- R8: A valid word that matches neither layout for the selected mode gives `rsvd_o`=1 for one cycle. It causes no write and leaves `ctrl_o` unchanged.
- R9: A valid matching word with `dsp_en_i`=0 gives `dsp_off_o`=1 for one cycle. It causes no write and leaves `ctrl_o` unchanged.
- R10: `ctrl_we_i` loads `ctrl_wdata_i` into `ctrl_o` at the next edge. This load takes priority over a flag set in the same cycle.
- R11: `wr_en_o`, `wr_idx_o` and `wr_data_o` update at the first rising edge after the cycle in which `valid_i` is high. `wr_en_o`, `rsvd_o` and `dsp_off_o` are low in the cycle after a cycle with `valid_i` low.
- R12: After a synchronous active-low reset, `wr_en_o`, `rsvd_o`, `dsp_off_o`, `wr_data_o` and `ctrl_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Instruction word present this cycle |
| insn_i | input | 32 | Instruction word |
| compact_i | input | 1 | 1 selects the compact layout |
| dsp_en_i | input | 1 | Execution permitted |
| src_a_idx_o | output | 5 | Source A register index (combinational) |
| src_b_idx_o | output | 5 | Source B register index (combinational) |
| src_a_data_i | input | 64 | Source A operand |
| src_b_data_i | input | 64 | Source B operand |
| wr_en_o | output | 1 | Destination write strobe |
| wr_idx_o | output | 5 | Destination register index |
| wr_data_o | output | 64 | Sign-extended saturated result |
| rsvd_o | output | 1 | Reserved-instruction pulse |
| dsp_off_o | output | 1 | Disabled-execution pulse |
| ctrl_we_i | input | 1 | Control register load strobe |
| ctrl_wdata_i | input | 32 | Control register load value |
| ctrl_o | output | 32 | Control register contents |

## Verification
The adder is swept over every pair drawn from a set of edge fractions: zero, ±1, both extremes, both half-scale values and their neighbours. Those pairs tell exact sums apart from positive and negative clamping and from sums that land exactly on a limit. Random garbage in the upper operand halves shows those bits are ignored. The sweep runs in both layouts with distinct source indices, which separates correct field extraction from a swapped one. Pseudo-random operand pairs then cover the interior of the range. Directed sequences cover the remaining control cases: sticky retention, preservation of the other control bits, load-over-set priority, a word in the wrong layout, and execution while disabled.

// File: rtl/q31_pkg.sv
// Package: shared constants and the decoded-instruction record.
// Assumes a 32-bit instruction word and 5-bit register indices.
package q31_pkg;
    localparam int INSN_W = 32;
    localparam int IDX_W  = 5;

    // full-width layout identifiers
    localparam logic [5:0]  STD_MAJOR = 6'b011111;
    localparam logic [4:0]  STD_OP    = 5'b10110;
    localparam logic [5:0]  STD_FUNC  = 6'b010000;
    // compact layout identifiers
    localparam logic [5:0]  CMP_MAJOR = 6'b000000;
    localparam logic [9:0]  CMP_MINOR = 10'b1100000101;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] src_a;
        logic [IDX_W-1:0] src_b;
        logic [IDX_W-1:0] dst;
    } dec_t;
endpackage

// File: rtl/q31_insn_decode.sv
// Module: decodes one instruction word in a single layout chosen by COMPACT.
// Assumes the word is stable for the whole cycle; purely combinational.
module q31_insn_decode
    import q31_pkg::*;
#(
    parameter bit COMPACT = 1'b0
) (
    input  logic [INSN_W-1:0] insn_i,
    output dec_t              dec_o
);
    generate
        if (COMPACT) begin : g_cmp
            // compact layout: source B field sits above source A
            always_comb begin
                dec_o.hit   = (insn_i[31:26] == CMP_MAJOR) && !insn_i[10]
                              && (insn_i[9:0] == CMP_MINOR);
                dec_o.src_b = insn_i[25:21];
                dec_o.src_a = insn_i[20:16];
                dec_o.dst   = insn_i[15:11];
            end
        end else begin : g_std
            // full-width layout: source A field sits above source B
            always_comb begin
                dec_o.hit   = (insn_i[31:26] == STD_MAJOR) && (insn_i[10:6] == STD_OP)
                              && (insn_i[5:0] == STD_FUNC);
                dec_o.src_a = insn_i[25:21];
                dec_o.src_b = insn_i[20:16];
                dec_o.dst   = insn_i[15:11];
            end
        end
    endgenerate
endmodule

// File: rtl/q31_sat_adder.sv
// Module: signed saturating add of the low WORD bits of two operands,
// result sign-extended to XLEN. Assumes XLEN > WORD; combinational.
module q31_sat_adder #(
    parameter int XLEN = 64,
    parameter int WORD = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] res_o,
    output logic            sat_o
);
    localparam logic [WORD-1:0] POS_LIM = {1'b0, {(WORD-1){1'b1}}};
    localparam logic [WORD-1:0] NEG_LIM = {1'b1, {(WORD-1){1'b0}}};

    logic [WORD:0]   sum_w;
    logic [WORD-1:0] clip;
    logic            unused_upper;

    assign unused_upper = ^{a_i[XLEN-1:WORD], b_i[XLEN-1:WORD]};

    // widen by one sign bit, add, detect overflow and clamp
    always_comb begin
        sum_w = {a_i[WORD-1], a_i[WORD-1:0]} + {b_i[WORD-1], b_i[WORD-1:0]};
        sat_o = sum_w[WORD] ^ sum_w[WORD-1];
        if (!sat_o)            clip = sum_w[WORD-1:0];
        else if (!sum_w[WORD]) clip = POS_LIM;
        else                   clip = NEG_LIM;
        res_o = {{(XLEN-WORD){clip[WORD-1]}}, clip};
    end

    // R4 R5: a clamped result is always one of the two limits with the sign of the inputs
    always_comb begin
        if (sat_o === 1'b1) begin
            clamp_value_chk: assert ((res_o[WORD-1:0] == POS_LIM && !a_i[WORD-1])
                                  || (res_o[WORD-1:0] == NEG_LIM && a_i[WORD-1]));
        end
    end
endmodule

// File: rtl/q31_ctrl_reg.sv
// Module: control register holding the sticky saturation flag.
// Assumes a software load has priority over a flag set in the same cycle.
module q31_ctrl_reg #(
    parameter int CTRL_W   = 32,
    parameter int FLAG_BIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              set_i,
    output logic [CTRL_W-1:0] q_o
);
    // load wins; otherwise OR in the flag
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= '0;
        else if (we_i)  q_o <= wdata_i;
        else if (set_i) q_o[FLAG_BIT] <= 1'b1;
    end

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o[FLAG_BIT] && !we_i) |=> q_o[FLAG_BIT]);
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !we_i) |=> q_o[FLAG_BIT]);
    // R10
    load_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> q_o == $past(wdata_i));
endmodule

// File: rtl/q31_sat_add_unit.sv
// Module: top of the Q31 saturating add unit. Decodes both layouts, selects by
// mode, adds, and registers the result and status one cycle after valid_i.
// Assumes the register file returns operands combinationally from the indices.
module q31_sat_add_unit
    import q31_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int WORD     = 32,
    parameter int CTRL_W   = 32,
    parameter int FLAG_BIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [31:0]       insn_i,
    input  logic              compact_i,
    input  logic              dsp_en_i,
    output logic [4:0]        src_a_idx_o,
    output logic [4:0]        src_b_idx_o,
    input  logic [XLEN-1:0]   src_a_data_i,
    input  logic [XLEN-1:0]   src_b_data_i,
    output logic              wr_en_o,
    output logic [4:0]        wr_idx_o,
    output logic [XLEN-1:0]   wr_data_o,
    output logic              rsvd_o,
    output logic              dsp_off_o,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    output logic [CTRL_W-1:0] ctrl_o
);
    localparam int N_LAYOUT = 2;

    dec_t            dec_q [N_LAYOUT];
    dec_t            dec_sel;
    logic [XLEN-1:0] sum_x;
    logic            sat;
    logic            do_write;
    logic            do_rsvd;
    logic            do_off;

    // one decoder per layout
    generate
        for (genvar g = 0; g < N_LAYOUT; g++) begin : g_dec
            q31_insn_decode #(.COMPACT(g == 1)) u_dec (
                .insn_i (insn_i),
                .dec_o  (dec_q[g])
            );
        end
    endgenerate

    // pick the layout named by the mode input
    assign dec_sel     = compact_i ? dec_q[1] : dec_q[0];
    assign src_a_idx_o = dec_sel.src_a;
    assign src_b_idx_o = dec_sel.src_b;

    q31_sat_adder #(.XLEN(XLEN), .WORD(WORD)) u_add (
        .a_i   (src_a_data_i),
        .b_i   (src_b_data_i),
        .res_o (sum_x),
        .sat_o (sat)
    );

    // classify this cycle's request
    always_comb begin
        do_write = valid_i && dec_sel.hit && dsp_en_i;
        do_rsvd  = valid_i && !dec_sel.hit;
        do_off   = valid_i && dec_sel.hit && !dsp_en_i;
    end

    // register result and status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
            rsvd_o    <= 1'b0;
            dsp_off_o <= 1'b0;
        end else begin
            wr_en_o   <= do_write;
            rsvd_o    <= do_rsvd;
            dsp_off_o <= do_off;
            if (do_write) begin
                wr_idx_o  <= dec_sel.dst;
                wr_data_o <= sum_x;
            end
        end
    end

    q31_ctrl_reg #(.CTRL_W(CTRL_W), .FLAG_BIT(FLAG_BIT)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ctrl_we_i),
        .wdata_i (ctrl_wdata_i),
        .set_i   (do_write && sat),
        .q_o     (ctrl_o)
    );

    // R8 R9
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en_o, rsvd_o, dsp_off_o}));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !(wr_en_o || rsvd_o || dsp_off_o));
    // R6
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_data_o[XLEN-1:WORD] == {(XLEN-WORD){wr_data_o[WORD-1]}}));
    // R8 R9
    no_flag_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((do_rsvd || do_off) && !ctrl_we_i) |=> $stable(ctrl_o));
endmodule

// File: tb/q31_sat_add_unit_tb.sv
module q31_sat_add_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic        compact_i = 1'b0;
    logic        dsp_en_i = 1'b1;
    logic [4:0]  src_a_idx_o, src_b_idx_o;
    logic [63:0] src_a_data_i, src_b_data_i;
    logic        wr_en_o;
    logic [4:0]  wr_idx_o;
    logic [63:0] wr_data_o;
    logic        rsvd_o, dsp_off_o;
    logic        ctrl_we_i = 1'b0;
    logic [31:0] ctrl_wdata_i = '0;
    logic [31:0] ctrl_o;

    logic [63:0] rf [32];
    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    localparam logic [4:0] IA = 5'd3, IB = 5'd17, ID = 5'd9;

    always #2 clk = ~clk;

    assign src_a_data_i = rf[src_a_idx_o];
    assign src_b_data_i = rf[src_b_idx_o];

    q31_sat_add_unit u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
        .compact_i(compact_i), .dsp_en_i(dsp_en_i),
        .src_a_idx_o(src_a_idx_o), .src_b_idx_o(src_b_idx_o),
        .src_a_data_i(src_a_data_i), .src_b_data_i(src_b_data_i),
        .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
        .rsvd_o(rsvd_o), .dsp_off_o(dsp_off_o),
        .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i), .ctrl_o(ctrl_o)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic logic [31:0] std_w(input logic [4:0] a, b, d);
        return {6'b011111, a, b, d, 5'b10110, 6'b010000};
    endfunction

    function automatic logic [31:0] cmp_w(input logic [4:0] a, b, d);
        return {6'b000000, b, a, d, 1'b0, 10'b1100000101};
    endfunction

    // arithmetic reference: exact sum, then clamp
    function automatic logic [63:0] ref_sum(input logic [31:0] a, b, output logic s);
        longint t;
        t = longint'($signed(a)) + longint'($signed(b));
        s = 1'b0;
        if (t > 64'sd2147483647)       begin t = 64'sd2147483647;  s = 1'b1; end
        else if (t < -64'sd2147483648) begin t = -64'sd2147483648; s = 1'b1; end
        return 64'(t);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic ctrl_load(input logic [31:0] d);
        @(negedge clk);
        ctrl_we_i = 1'b1; ctrl_wdata_i = d;
        @(negedge clk);
        ctrl_we_i = 1'b0;
    endtask

    // issue one word; index outputs are checked in the issue cycle,
    // registered outputs at the next negedge
    task automatic issue(input logic [31:0] w, input logic cmp, input logic en,
                         input logic idx_chk, input string req);
        @(negedge clk);
        insn_i = w; compact_i = cmp; dsp_en_i = en; valid_i = 1'b1;
        #1;
        if (idx_chk) begin
            chk({req, " src A index"}, 64'(src_a_idx_o), 64'(IA));
            chk({req, " src B index"}, 64'(src_b_idx_o), 64'(IB));
        end
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic add_case(input logic [31:0] a, input logic [31:0] b, input logic cmp);
        logic s;
        logic [63:0] e;
        seed = nxt(seed);
        rf[IA] = {seed, a};
        seed = nxt(seed);
        rf[IB] = {seed, b};
        e = ref_sum(a, b, s);
        ctrl_load(32'h0);
        issue(cmp ? cmp_w(IA, IB, ID) : std_w(IA, IB, ID), cmp, 1'b1, 1'b1, cmp ? "R2" : "R1");
        chk("R11 write strobe", 64'(wr_en_o), 64'd1);
        chk(cmp ? "R2 dest index" : "R1 dest index", 64'(wr_idx_o), 64'(ID));
        chk(s ? (e[31] ? "R5 R6 result" : "R4 R6 result") : "R3 R6 result", wr_data_o, e);
        chk("R7 flag", 64'(ctrl_o), s ? 64'h0010_0000 : 64'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] vals [12];
        vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h4000_0000,
                 32'hC000_0000, 32'h3FFF_FFFF, 32'h8000_0001, 32'h7FFF_FFFE, 32'h4000_0001,
                 32'hBFFF_FFFF};
        for (int i = 0; i < 32; i++) rf[i] = 64'(i) * 64'h0101_0101_0101_0101;

        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 wr_en", 64'(wr_en_o), 64'd0);
        chk("R12 rsvd", 64'(rsvd_o), 64'd0);
        chk("R12 dsp_off", 64'(dsp_off_o), 64'd0);
        chk("R12 wr_data", wr_data_o, 64'd0);
        chk("R12 ctrl", 64'(ctrl_o), 64'd0);
        rst_n = 1'b1;

        // edge-value sweep, both layouts (R1..R7)
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    add_case(vals[i], vals[j], m[0]);
        // pseudo-random interior (R3..R6)
        for (int k = 0; k < 300; k++) begin
            logic [31:0] a, b;
            seed = nxt(seed); a = seed;
            seed = nxt(seed); b = seed >> (k % 3);
            add_case(a, b, k[0]);
        end

        // R11: idle cycle after a write drops the strobe
        @(negedge clk);
        chk("R11 idle strobe", 64'(wr_en_o), 64'd0);

        // R7: other bits kept, flag sticky across a non-saturating add
        rf[IA] = 64'h7FFF_FFFF; rf[IB] = 64'h1;
        ctrl_load(32'h0000_00F0);
        issue(std_w(IA, IB, ID), 1'b0, 1'b1, 1'b0, "R7");
        chk("R7 set keeps others", 64'(ctrl_o), 64'h0010_00F0);
        rf[IB] = 64'hFFFF_FFFF_FFFF_FFFF;
        issue(std_w(IA, IB, ID), 1'b0, 1'b1, 1'b0, "R7");
        chk("R7 sticky", 64'(ctrl_o), 64'h0010_00F0);
        chk("R7 plain result", wr_data_o, 64'h0000_0000_7FFF_FFFE);

        // R10: load alone, then load colliding with a flag set
        ctrl_load(32'hA5A5_5A5A);
        chk("R10 load", 64'(ctrl_o), 64'hA5A5_5A5A);
        rf[IB] = 64'h1;
        @(negedge clk);
        insn_i = std_w(IA, IB, ID); compact_i = 1'b0; dsp_en_i = 1'b1; valid_i = 1'b1;
        ctrl_we_i = 1'b1; ctrl_wdata_i = 32'h0000_0003;
        @(negedge clk);
        valid_i = 1'b0; ctrl_we_i = 1'b0;
        chk("R10 priority", 64'(ctrl_o), 64'h0000_0003);
        chk("R10 write still done", 64'(wr_en_o), 64'd1);

        // R8: wrong layout for the mode, both directions, saturating operands
        ctrl_load(32'h0);
        issue(std_w(IA, IB, ID), 1'b1, 1'b1, 1'b0, "R8");
        chk("R8 rsvd", 64'(rsvd_o), 64'd1);
        chk("R8 no write", 64'(wr_en_o), 64'd0);
        chk("R8 ctrl kept", 64'(ctrl_o), 64'd0);
        issue(cmp_w(IA, IB, ID), 1'b0, 1'b1, 1'b0, "R8");
        chk("R8 rsvd std", 64'(rsvd_o), 64'd1);
        chk("R8 ctrl kept std", 64'(ctrl_o), 64'd0);
        issue(cmp_w(IA, IB, ID) | 32'h0000_0400, 1'b1, 1'b1, 1'b0, "R8");
        chk("R8 bit10 set", 64'(rsvd_o), 64'd1);

        // R9: disabled execution
        issue(std_w(IA, IB, ID), 1'b0, 1'b0, 1'b0, "R9");
        chk("R9 dsp_off", 64'(dsp_off_o), 64'd1);
        chk("R9 no write", 64'(wr_en_o), 64'd0);
        chk("R9 no rsvd", 64'(rsvd_o), 64'd0);
        chk("R9 ctrl kept", 64'(ctrl_o), 64'd0);
        @(negedge clk);
        chk("R11 pulse ends", 64'(dsp_off_o), 64'd0);

        summary();
    end
endmodule